// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a free-running down-counter that gives an operating system its periodic tick. Software programs a reload value, sets an enable bit, and the counter then steps down from that value to zero. At zero it reloads and starts the next period. Each expiry sets a sticky flag in the control/status register and, if interrupts are allowed, raises a one-cycle interrupt request. The tick rate is therefore set entirely by the reload value. For example, a 1 MHz step rate and a reload of 9999 give a 100 Hz tick.

The counter steps on every clock when the core-clock source bit is set. Otherwise it steps only on cycles where the `tick_en` input is high; a slower reference clock is represented by this single clock-enable input. A write of any data to the current-value register zeroes the counter and drops the flag. Reading the control/status register clears the flag, so software can poll it to learn whether a period has passed since its last look.

A small sequencer tracks the position in the period with three states:
- **ST_EMPTY**: the count is zero and the next step loads the reload value.
- **ST_COUNT**: the count is above one.
- **ST_LAST**: the count is one and the next step expires.

Its transitions are:
- EMPTY→COUNT: a step with a reload value above one.
- EMPTY→LAST: a step with a reload value of one.
- EMPTY→EMPTY: a step with a reload value of zero.
- COUNT→LAST: a step at a count of two.
- LAST→EMPTY: a step, which is the expiry.
- Any state→EMPTY: a write to the current-value register.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The register map is: address 0 is control/status, address 1 is the reload value, address 2 is the current value, and address 3 reads zero.
- R2: With the run bit (control bit 0) set, the count drops by one per step. A step occurs on every clock when the core-source bit (control bit 2) is 1, and only on clocks with `tick_en` high when that bit is 0.
- R3: A step at count zero loads the reload value. With a nonzero reload value R, the count period is R+1 steps. An expiry is the step that takes the count from 1 to 0.
- R4: An expiry sets the flag, which reads at bit 16 of address 0. A read of address 0 clears the flag at the end of the read cycle. If an expiry falls in that same cycle, the flag stays set.
- R5: A write of any data to address 2 zeroes the count and clears the flag. This write takes priority over a step in the same cycle.
- R6: `irq` pulses high for one cycle, the cycle after an expiry, and only when the interrupt-enable bit (control bit 1) is set.
- R7: With a reload value of zero, the counter stays at zero and never expires: the flag stays clear and `irq` stays low.
- R8: With the run bit clear, the count holds its value.
- R9: Only the low CNT_W bits of a reload write are kept, and the bits above them read zero. Address 0 keeps only bits 2:0 and reads zero outside bits 2:0 and bit 16. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference-rate step enable, used when the core-source bit is 0 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 0 clears the flag |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| irq | output | 1 | One-cycle interrupt request after an expiry |

## Verification
The bench builds the block with CNT_W = 5 and DATA_W = 32. This makes every possible reload value, from 0 through 31, reachable in a full sweep in which each value runs through several complete periods in a few dozen clocks. For each value, the expected count, the number of expiries and the flag state are computed from the step total by modular arithmetic. Directed cases then cover:
- stepping through the reference-rate input;
- a flag read that lands on the expiry cycle;
- a clearing write during counting;
- truncation of oversized writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Sequencer position within one count period
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_COUNT = 2'd1,
        ST_LAST  = 2'd2
    } seq_state_e;

    // Register addresses
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_LOAD = 2'd1;
    localparam logic [1:0] REG_CUR  = 2'd2;

    // Control/status field positions
    localparam int CTRL_W   = 3;
    localparam int FLAG_BIT = 16;

    // Packed control fields: bit 2 core source, bit 1 irq enable, bit 0 run
    typedef struct packed {
        logic core_src;
        logic irq_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cur_val,
    input  logic              wrap_evt,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              flag_q,
    output logic              clr_cnt,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic wr_ctrl;
    logic wr_load;
    logic rd_ctrl;
    logic wdata_unused;

    assign wr_ctrl      = wr_en && (addr == REG_CTRL);
    assign wr_load      = wr_en && (addr == REG_LOAD);
    assign clr_cnt      = wr_en && (addr == REG_CUR);
    assign rd_ctrl      = rd_en && (addr == REG_CTRL);
    assign wdata_unused = ^wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            end
            if (wr_load) begin
                reload_q <= wdata[CNT_W-1:0];
            end
        end
    end

    // Sticky flag: an expiry wins over either clearing source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wrap_evt) begin
            flag_q <= 1'b1;
        end else if (clr_cnt || rd_ctrl) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[CTRL_W-1:0] = ctrl_q;
                rdata[FLAG_BIT]   = flag_q;
            end
            REG_LOAD: rdata = {{PAD_W{1'b0}}, reload_q};
            REG_CUR:  rdata = {{PAD_W{1'b0}}, cur_val};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_timer_seq.sv
module tick_timer_seq
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_q,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] reload_q,
    input  logic             clr_cnt,
    output logic [CNT_W-1:0] cur_q,
    output logic             step,
    output logic             wrap_evt,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    seq_state_e       state_q;
    seq_state_e       state_nxt;
    logic [CNT_W-1:0] cur_nxt;

    assign step = ctrl_q.run && (ctrl_q.core_src || tick_en);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        if (clr_cnt) begin
            state_nxt = ST_EMPTY;
        end else if (step) begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (reload_q == '0) begin
                        state_nxt = ST_EMPTY;
                    end else if (reload_q == ONE) begin
                        state_nxt = ST_LAST;
                    end else begin
                        state_nxt = ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (cur_q == TWO) begin
                        state_nxt = ST_LAST;
                    end
                end
                ST_LAST:  state_nxt = ST_EMPTY;
                default:  state_nxt = ST_EMPTY;
            endcase
        end
    end

    // Outputs: next count value and expiry
    always_comb begin
        cur_nxt  = cur_q;
        wrap_evt = 1'b0;
        if (clr_cnt) begin
            cur_nxt = '0;
        end else if (step) begin
            unique case (state_q)
                ST_EMPTY: cur_nxt = reload_q;
                ST_COUNT: cur_nxt = cur_q - ONE;
                ST_LAST: begin
                    cur_nxt  = '0;
                    wrap_evt = 1'b1;
                end
                default:  cur_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            irq   <= 1'b0;
        end else begin
            cur_q <= cur_nxt;
            irq   <= wrap_evt && ctrl_q.irq_en;
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_q;
    logic             flag_q;
    logic             clr_cnt;
    logic             step;
    logic             wrap_evt;

    tick_timer_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .cur_val  (cur_q),
        .wrap_evt (wrap_evt),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .flag_q   (flag_q),
        .clr_cnt  (clr_cnt),
        .rdata    (rdata)
    );

    tick_timer_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_q   (ctrl_q),
        .tick_en  (tick_en),
        .reload_q (reload_q),
        .clr_cnt  (clr_cnt),
        .cur_q    (cur_q),
        .step     (step),
        .wrap_evt (wrap_evt),
        .irq      (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cur_q,
    input logic              flag_q,
    input logic              step
);

    logic wr_cur;
    assign wr_cur = wr_en && (addr == REG_CUR);

    // R5
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur |=> (cur_q == '0) && !flag_q);

    // R2
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_cur && (cur_q > CNT_W'(1))) |=> (cur_q == $past(cur_q) - CNT_W'(1)));

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_cur && (cur_q == '0)) |=> (cur_q == $past(reload_q)));

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_cur) |=> $stable(cur_q));

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl_q.irq_en));

    // R7
    zero_reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reload_q == '0) && (cur_q == '0)) |=> (cur_q == '0) && !irq);

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr != REG_CTRL)) |-> (rdata[DATA_W-1:CNT_W] == '0));

endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .irq      (irq),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q),
    .cur_q    (cur_q),
    .flag_q   (flag_q),
    .step     (step)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;

    localparam int CNT_W  = 5;
    localparam int DATA_W = 32;
    localparam int MAXV   = (1 << CNT_W) - 1;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LOAD = 2'd1;
    localparam logic [1:0] A_CUR  = 2'd2;
    localparam logic [1:0] A_NONE = 2'd3;
    localparam logic [31:0] FLAG  = 32'h0001_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [1:0]        addr = 2'd0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    tick_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd(A_CTRL, d); chk(d == 0, "R1 ctrl after reset", d, 0);
        rd(A_LOAD, d); chk(d == 0, "R1 reload after reset", d, 0);
        rd(A_CUR, d);  chk(d == 0, "R1 count after reset", d, 0);
        chk(irq == 0, "R1 irq after reset", 32'(irq), 0);

        // R2 R3 R4 R6 R7 sweep over every reload value, core clock
        for (int r = 0; r <= MAXV; r++) begin
            int k, s, ev, p, ec;
            k = 2 * r + 3 + (r % 4);
            wr(A_LOAD, 32'(r));
            wr(A_CUR, 32'hA5A5_0000);
            base = irq_cnt;
            wr(A_CTRL, 32'h7);
            repeat (k) @(posedge clk);
            #1;
            wr(A_CTRL, 32'h0);
            s = k + 1;
            if (r == 0) begin
                ev = 0; ec = 0;
            end else begin
                ev = s / (r + 1);
                p  = s % (r + 1);
                ec = (p == 0) ? 0 : r - p + 1;
            end
            repeat (2) @(posedge clk);
            #1;
            rd(A_CUR, d);
            chk(d == 32'(ec), $sformatf("R3 count reload=%0d", r), d, 32'(ec));
            chk(irq_cnt - base == ev, $sformatf("R6 irq pulses reload=%0d", r),
                32'(irq_cnt - base), 32'(ev));
            rd(A_CTRL, d);
            chk(d == ((ev > 0) ? FLAG : 0), $sformatf("R4 flag reload=%0d (R7 if 0)", r),
                d, (ev > 0) ? FLAG : 0);
            rd(A_CTRL, d);
            chk(d == 0, $sformatf("R4 flag cleared by read reload=%0d", r), d, 0);
        end

        // R2 reference-rate stepping through tick_en
        wr(A_LOAD, 32'd4);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h3);
        repeat (10) @(posedge clk);
        #1;
        rd(A_CUR, d); chk(d == 0, "R2 no step without tick_en", d, 0);
        base = irq_cnt;
        for (int i = 0; i < 7; i++) begin
            tick_en = 1'b1;
            @(posedge clk); #1;
            tick_en = 1'b0;
            repeat (2) @(posedge clk);
            #1;
        end
        wr(A_CTRL, 32'h0);
        rd(A_CUR, d); chk(d == 3, "R2 count after 7 tick_en steps", d, 3);
        chk(irq_cnt - base == 1, "R2 one expiry in 7 steps", 32'(irq_cnt - base), 1);

        // R8 hold while stopped
        repeat (5) @(posedge clk);
        #1;
        rd(A_CUR, d); chk(d == 3, "R8 count holds when run is clear", d, 3);
        rd(A_CTRL, d);

        // R6 irq suppressed when irq enable is clear
        wr(A_LOAD, 32'd3);
        wr(A_CUR, 32'd0);
        base = irq_cnt;
        wr(A_CTRL, 32'h5);
        repeat (8) @(posedge clk);
        #1;
        wr(A_CTRL, 32'h0);
        repeat (2) @(posedge clk);
        #1;
        rd(A_CUR, d); chk(d == 3, "R6 count with irq disabled", d, 3);
        chk(irq_cnt == base, "R6 no irq when disabled", 32'(irq_cnt - base), 0);
        rd(A_CTRL, d); chk(d == FLAG, "R6 flag still set when irq disabled", d, FLAG);

        // R4 read on the expiry cycle keeps the flag
        wr(A_LOAD, 32'd2);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h7);
        repeat (2) @(posedge clk);
        #1;
        rd(A_CTRL, d); chk(d == 32'h7, "R4 flag clear before expiry", d, 32'h7);
        rd(A_CTRL, d); chk(d == (FLAG | 32'h7), "R4 set wins over read clear", d, FLAG | 32'h7);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d);

        // R5 clearing write while counting
        wr(A_LOAD, 32'd10);
        wr(A_CUR, 32'd0);
        wr(A_CTRL, 32'h5);
        repeat (24) @(posedge clk);
        #1;
        wr(A_CUR, 32'h1234_5678);
        rd(A_CUR, d); chk(d == 0, "R5 count zero after write", d, 0);
        rd(A_CTRL, d); chk(d == 32'h5, "R5 flag cleared by write", d, 32'h5);
        wr(A_CTRL, 32'h0);

        // R9 truncation and unused address
        wr(A_LOAD, 32'hFFFF_FFFF);
        rd(A_LOAD, d); chk(d == 32'(MAXV), "R9 reload truncated", d, 32'(MAXV));
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd(A_CTRL, d); chk(d == 0, "R9 ctrl upper bits dropped", d, 0);
        wr(A_NONE, 32'hFFFF_FFFF);
        rd(A_NONE, d); chk(d == 0, "R9 address 3 reads zero", d, 0);
        rd(A_LOAD, d); chk(d == 32'(MAXV), "R9 address 3 write ignored", d, 32'(MAXV));
        rd(A_CTRL, d); chk(d == 0, "R9 ctrl untouched by address 3", d, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule